// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside the decode and memory stages of a simple in-order pipelined core and turns exception requests into an architectural entry. Each cycle the core presents a vector of request lines, one per exception source, along with the PC of the faulting instruction, the PC that would have followed it, a faulting data or fetch address and a coprocessor number. When any request line is high, the block picks the single winning source by fixed priority and updates its registers at the next clock edge: the exception code, branch-delay flag and coprocessor field, the exception PC, the bad-address register, the TLB faulting-page fields, the exception-level bit and the shadow register-set selectors. In the same edge it raises a one-cycle `taken` pulse together with the handler fetch address, so the fetch stage can flush and redirect.

The controller also owns the boot-vector select bit, the exception base register and the shadow-set fields. Software loads these through a simple write port. The handler address depends on the winning source and on the exception-level and boot-vector bits as they stood before the entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: One clock edge after any bit of `req_vec` is high, `taken` is 1 for exactly that cycle and `fetch_addr` holds the handler address. After a cycle with no request, `taken` is 0 and `fetch_addr` is unchanged.
- R2: When several request bits are high, the lowest bit index wins and the others are dropped. The bit map is: 0 reset, 1 interrupt, 2 fetch address error, 3 fetch TLB refill, 4 fetch TLB invalid, 5 reserved instruction, 6 coprocessor unusable, 7 system call, 8 breakpoint, 9 arithmetic overflow, 10 trap, 11 load address error, 12 store address error, 13 load TLB refill, 14 store TLB refill, 15 load TLB invalid, 16 store TLB invalid, 17 TLB modified.
- R3: `cause_code` takes the 5-bit code of the winner: interrupt 0x0, TLB modified 0x1, TLB refill or invalid on fetch or load 0x2, on store 0x3, address error on fetch or load 0x4, on store 0x5, system call 0x8, breakpoint 0x9, reserved instruction 0xA, coprocessor unusable 0xB, overflow 0xC, trap 0xD.
- R4: For every non-reset entry: if `pc + 4 != next_pc`, `epc` becomes `pc - 4` and `cause_bd` becomes 1. Otherwise `epc` becomes `pc` and `cause_bd` becomes 0.
- R5: Every entry sets `status_exl` to 1, whether it was set before or not.
- R6: On a non-reset entry with both `status_exl` and `status_bev` clear beforehand, `srs_pss` takes the old `srs_css` and `srs_css` takes `srs_ess`. Otherwise both fields hold their values.
- R7: A general (non-refill, non-reset) entry vectors to `ebase + 0x180` when `status_bev` is 0 and to 0xBFC00200 when it is 1.
- R8: A TLB refill entry (request bits 3, 13 and 14) vectors to `ebase + 0x000` if `status_exl` was clear before the entry, and to `ebase + 0x180` if it was set. `status_bev` does not affect this choice.
- R9: An interrupt entry with `status_bev` 0 vectors to `ebase + 0x200` when `cause_iv` is 1, and to `ebase + 0x180` when it is 0.
- R10: Asserting `rst_n` low, or winning with request bit 0, sets `fetch_addr` to 0xBFC00000 and sets `status_exl` and `status_bev` to 1. A reset request leaves the cause fields, `epc` and the shadow fields unchanged.
- R11: A coprocessor-unusable entry writes `cop_id` into `cause_ce`. Every other non-reset entry clears `cause_ce` to 0.
- R12: Address-error and TLB entries (bits 2, 3, 4 and 11 to 17) load `fault_addr` into `badvaddr`. TLB entries (bits 3, 4 and 13 to 17) also load `fault_addr[31:13]` into `entryhi_vpn2` and `context_vpn2`. Other entries leave these registers unchanged.
- R13: With `sw_we` high and no request, `sw_sel` picks the register to write. 0 is status, with bit 0 as exl and bit 1 as bev. 1 is the cause interrupt-vector bit, from bit 0. 2 is ebase, from bits 31:12 with the low 12 bits forced to 0. 3 is the shadow fields, with ess in bits 3:0, css in bits 7:4 and pss in bits 11:8. 4 is epc. If a request and a software write arrive in the same cycle, the entry wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vec | input | 18 | Exception request lines, one per source (bit map in R2) |
| pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | PC that would follow the faulting instruction |
| fault_addr | input | 32 | Faulting fetch or data address |
| cop_id | input | 2 | Coprocessor number for coprocessor-unusable |
| sw_we | input | 1 | Software register write enable |
| sw_sel | input | 3 | Software write register select |
| sw_wdata | input | 32 | Software write data |
| taken | output | 1 | One-cycle entry pulse |
| fetch_addr | output | 32 | Handler (redirect) fetch address |
| status_exl | output | 1 | Exception-level bit |
| status_bev | output | 1 | Boot-vector select bit |
| ebase | output | 32 | Exception base register |
| srs_ess | output | 4 | Shadow set used on exception entry |
| srs_css | output | 4 | Current shadow set |
| srs_pss | output | 4 | Previous shadow set |
| cause_code | output | 5 | Exception code |
| cause_bd | output | 1 | Branch-delay flag |
| cause_ce | output | 2 | Coprocessor number field |
| cause_iv | output | 1 | Interrupt vector select |
| epc | output | 32 | Exception PC |
| badvaddr | output | 32 | Faulting address register |
| entryhi_vpn2 | output | 19 | Faulting page number in the TLB entry-high register |
| context_vpn2 | output | 19 | Faulting page number in the context register |

## Verification
The bench builds the block with its defaults: 4-bit shadow fields, a page shift of 13, a 2-bit coprocessor field and the 0xBFC00000 / 0xBFC00200 boot vectors. These bring every entry path within reach with fixed, hand-computable addresses. The 4-bit shadow fields let three distinct values sit in ess, css and pss at once, so a rotation, a hold and a partial copy can all be told apart. The page shift of 13 makes the faulting page number a plain right shift that the bench computes itself.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int ADDR_W = 32;
  localparam int NREQ   = 18;
  localparam int IDX_W  = $clog2(NREQ);
  localparam int CODE_W = 5;

  // request bit positions, lowest index = highest priority
  localparam int RQ_RESET = 0,  RQ_IRQ = 1,   RQ_IF_ADDR = 2, RQ_IF_REFILL = 3;
  localparam int RQ_IF_INV = 4, RQ_ILLEGAL = 5, RQ_COP_OFF = 6, RQ_SYSCALL = 7;
  localparam int RQ_BREAK = 8,  RQ_OVFL = 9,  RQ_TRAP = 10,   RQ_LD_ADDR = 11;
  localparam int RQ_ST_ADDR = 12, RQ_LD_REFILL = 13, RQ_ST_REFILL = 14;
  localparam int RQ_LD_INV = 15, RQ_ST_INV = 16, RQ_TLB_MOD = 17;

  localparam logic [CODE_W-1:0] EC_IRQ = 5'h00, EC_TLB_MOD = 5'h01;
  localparam logic [CODE_W-1:0] EC_TLB_LD = 5'h02, EC_TLB_ST = 5'h03;
  localparam logic [CODE_W-1:0] EC_ADDR_LD = 5'h04, EC_ADDR_ST = 5'h05;
  localparam logic [CODE_W-1:0] EC_SYSCALL = 5'h08, EC_BREAK = 5'h09;
  localparam logic [CODE_W-1:0] EC_ILLEGAL = 5'h0A, EC_COP_OFF = 5'h0B;
  localparam logic [CODE_W-1:0] EC_OVFL = 5'h0C, EC_TRAP = 5'h0D;

  localparam logic [ADDR_W-1:0] OFS_REFILL = 32'h0000_0000;
  localparam logic [ADDR_W-1:0] OFS_GENERAL = 32'h0000_0180;
  localparam logic [ADDR_W-1:0] OFS_VEC_IRQ = 32'h0000_0200;

  localparam logic [2:0] SW_STATUS = 3'd0, SW_CAUSE = 3'd1, SW_EBASE = 3'd2;
  localparam logic [2:0] SW_SHADOW = 3'd3, SW_EPC = 3'd4;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic rst;
    logic irq;
    logic cop;
    logic tlb;
    logic refill;
    logic badva;
  } exc_attr_t;

  function automatic exc_attr_t attr_of(input logic [IDX_W-1:0] idx);
    exc_attr_t a;
    a = '0;
    case (int'(idx))
      RQ_RESET:     a.rst = 1'b1;
      RQ_IRQ:       begin a.code = EC_IRQ; a.irq = 1'b1; end
      RQ_IF_ADDR:   begin a.code = EC_ADDR_LD; a.badva = 1'b1; end
      RQ_IF_REFILL: begin a.code = EC_TLB_LD; a.tlb = 1'b1; a.refill = 1'b1; a.badva = 1'b1; end
      RQ_IF_INV:    begin a.code = EC_TLB_LD; a.tlb = 1'b1; a.badva = 1'b1; end
      RQ_ILLEGAL:   a.code = EC_ILLEGAL;
      RQ_COP_OFF:   begin a.code = EC_COP_OFF; a.cop = 1'b1; end
      RQ_SYSCALL:   a.code = EC_SYSCALL;
      RQ_BREAK:     a.code = EC_BREAK;
      RQ_OVFL:      a.code = EC_OVFL;
      RQ_TRAP:      a.code = EC_TRAP;
      RQ_LD_ADDR:   begin a.code = EC_ADDR_LD; a.badva = 1'b1; end
      RQ_ST_ADDR:   begin a.code = EC_ADDR_ST; a.badva = 1'b1; end
      RQ_LD_REFILL: begin a.code = EC_TLB_LD; a.tlb = 1'b1; a.refill = 1'b1; a.badva = 1'b1; end
      RQ_ST_REFILL: begin a.code = EC_TLB_ST; a.tlb = 1'b1; a.refill = 1'b1; a.badva = 1'b1; end
      RQ_LD_INV:    begin a.code = EC_TLB_LD; a.tlb = 1'b1; a.badva = 1'b1; end
      RQ_ST_INV:    begin a.code = EC_TLB_ST; a.tlb = 1'b1; a.badva = 1'b1; end
      RQ_TLB_MOD:   begin a.code = EC_TLB_MOD; a.tlb = 1'b1; a.badva = 1'b1; end
      default:      a = '0;
    endcase
    return a;
  endfunction

  // handler address for a non-reset entry; exl and bev are pre-entry values
  function automatic logic [ADDR_W-1:0] pick_vector(
      input logic refill, input logic irq, input logic iv,
      input logic exl, input logic bev,
      input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] boot_vec);
    if (refill)          return base + (exl ? OFS_GENERAL : OFS_REFILL);
    else if (bev)        return boot_vec;
    else if (irq && iv)  return base + OFS_VEC_IRQ;
    else                 return base + OFS_GENERAL;
  endfunction

  // returns {delay_slot_flag, exception_pc}
  function automatic logic [ADDR_W:0] rewind_epc(
      input logic [ADDR_W-1:0] cur_pc, input logic [ADDR_W-1:0] nxt_pc);
    logic slot;
    slot = (cur_pc + 32'd4) != nxt_pc;
    return {slot, slot ? (cur_pc - 32'd4) : cur_pc};
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N  = 18,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          fire,
  output logic [IW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar gi = 0; gi < N; gi++) begin : g_chain
    assign grant[gi]  = req[gi] & ~seen[gi];
    assign seen[gi+1] = seen[gi] | req[gi];
  end

  assign fire = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) idx = idx | IW'(i);
  end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BOOT_VEC  = 32'hBFC0_0200
) (
  input  logic              is_reset,
  input  logic              is_refill,
  input  logic              is_irq,
  input  logic              iv,
  input  logic              exl,
  input  logic              bev,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] nxt_pc,
  output logic [ADDR_W-1:0] handler,
  output logic [ADDR_W-1:0] epc_new,
  output logic              in_slot
);
  logic [ADDR_W:0] rw;

  assign handler = is_reset ? RESET_VEC
                            : pick_vector(is_refill, is_irq, iv, exl, bev, base, BOOT_VEC);
  assign rw      = rewind_epc(cur_pc, nxt_pc);
  assign in_slot = rw[ADDR_W];
  assign epc_new = rw[ADDR_W-1:0];
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int                SRS_W     = 4,
  parameter int                VPN_LSB   = 13,
  parameter int                COP_W     = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BOOT_VEC  = 32'hBFC0_0200,
  parameter logic [ADDR_W-1:0] EBASE_RST = 32'h8000_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_vec,
  input  logic [ADDR_W-1:0]        pc,
  input  logic [ADDR_W-1:0]        next_pc,
  input  logic [ADDR_W-1:0]        fault_addr,
  input  logic [COP_W-1:0]         cop_id,
  input  logic                     sw_we,
  input  logic [2:0]               sw_sel,
  input  logic [ADDR_W-1:0]        sw_wdata,
  output logic                     taken,
  output logic [ADDR_W-1:0]        fetch_addr,
  output logic                     status_exl,
  output logic                     status_bev,
  output logic [ADDR_W-1:0]        ebase,
  output logic [SRS_W-1:0]         srs_ess,
  output logic [SRS_W-1:0]         srs_css,
  output logic [SRS_W-1:0]         srs_pss,
  output logic [CODE_W-1:0]        cause_code,
  output logic                     cause_bd,
  output logic [COP_W-1:0]         cause_ce,
  output logic                     cause_iv,
  output logic [ADDR_W-1:0]        epc,
  output logic [ADDR_W-1:0]        badvaddr,
  output logic [ADDR_W-VPN_LSB-1:0] entryhi_vpn2,
  output logic [ADDR_W-VPN_LSB-1:0] context_vpn2
);
  localparam int VPN_W   = ADDR_W - VPN_LSB;
  localparam int BASE_LO = 12;

  // named internal events
  logic             exc_fire;
  logic [IDX_W-1:0] sel_idx;
  exc_attr_t        sel_attr;
  logic [CODE_W-1:0] sel_code;
  logic             sel_is_reset;
  logic             sel_is_refill;
  logic             rotate_en;
  logic             in_slot;
  logic [ADDR_W-1:0] handler;
  logic [ADDR_W-1:0] epc_new;

  exc_prio_sel #(.N(NREQ), .IW(IDX_W)) u_prio (
    .req  (req_vec),
    .fire (exc_fire),
    .idx  (sel_idx)
  );

  assign sel_attr      = attr_of(sel_idx);
  assign sel_code      = sel_attr.code;
  assign sel_is_reset  = sel_attr.rst;
  assign sel_is_refill = sel_attr.refill;
  assign rotate_en     = exc_fire && !sel_attr.rst && !status_exl && !status_bev;

  exc_vector_calc #(.RESET_VEC(RESET_VEC), .BOOT_VEC(BOOT_VEC)) u_vec (
    .is_reset  (sel_attr.rst),
    .is_refill (sel_attr.refill),
    .is_irq    (sel_attr.irq),
    .iv        (cause_iv),
    .exl       (status_exl),
    .bev       (status_bev),
    .base      (ebase),
    .cur_pc    (pc),
    .nxt_pc    (next_pc),
    .handler   (handler),
    .epc_new   (epc_new),
    .in_slot   (in_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken        <= 1'b0;
      fetch_addr   <= RESET_VEC;
      status_exl   <= 1'b1;
      status_bev   <= 1'b1;
      ebase        <= EBASE_RST;
      srs_ess      <= '0;
      srs_css      <= '0;
      srs_pss      <= '0;
      cause_code   <= '0;
      cause_bd     <= 1'b0;
      cause_ce     <= '0;
      cause_iv     <= 1'b0;
      epc          <= '0;
      badvaddr     <= '0;
      entryhi_vpn2 <= '0;
      context_vpn2 <= '0;
    end else begin
      taken <= exc_fire;
      if (exc_fire) begin
        fetch_addr <= handler;
        status_exl <= 1'b1;
        if (sel_attr.rst) begin
          status_bev <= 1'b1;
        end else begin
          if (rotate_en) begin
            srs_pss <= srs_css;
            srs_css <= srs_ess;
          end
          cause_code <= sel_attr.code;
          cause_bd   <= in_slot;
          cause_ce   <= sel_attr.cop ? cop_id : '0;
          epc        <= epc_new;
          if (sel_attr.badva) badvaddr <= fault_addr;
          if (sel_attr.tlb) begin
            entryhi_vpn2 <= fault_addr[ADDR_W-1:VPN_LSB];
            context_vpn2 <= fault_addr[ADDR_W-1:VPN_LSB];
          end
        end
      end else if (sw_we) begin
        case (sw_sel)
          SW_STATUS: begin
            status_exl <= sw_wdata[0];
            status_bev <= sw_wdata[1];
          end
          SW_CAUSE:  cause_iv <= sw_wdata[0];
          SW_EBASE:  ebase <= {sw_wdata[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}};
          SW_SHADOW: begin
            srs_ess <= sw_wdata[SRS_W-1:0];
            srs_css <= sw_wdata[2*SRS_W-1:SRS_W];
            srs_pss <= sw_wdata[3*SRS_W-1:2*SRS_W];
          end
          SW_EPC:    epc <= sw_wdata;
          default:   ;
        endcase
      end
    end
  end

  logic unused_vpn_w;
  assign unused_vpn_w = (VPN_W > 0);
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int                SRS_W     = 4,
  parameter int                COP_W     = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREQ-1:0]   req_vec,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] next_pc,
  input logic              taken,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              status_exl,
  input logic              status_bev,
  input logic [ADDR_W-1:0] ebase,
  input logic [SRS_W-1:0]  srs_ess,
  input logic [SRS_W-1:0]  srs_css,
  input logic [SRS_W-1:0]  srs_pss,
  input logic              cause_bd,
  input logic [COP_W-1:0]  cause_ce,
  input logic              exc_fire,
  input logic [CODE_W-1:0] sel_code,
  input logic              sel_is_reset,
  input logic              sel_is_refill
);
  // R1
  taken_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_vec) |=> taken);

  // R1
  no_spurious_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_vec) |=> !taken);

  // R5
  exl_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> status_exl);

  // R6
  srs_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && !sel_is_reset && !status_exl && !status_bev) |=>
      (srs_pss == $past(srs_css)) && (srs_css == $past(srs_ess)));

  // R6
  srs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && (status_exl || status_bev)) |=> $stable(srs_css) && $stable(srs_pss));

  // R4
  delay_slot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && !sel_is_reset) |=> cause_bd == (($past(pc) + 32'd4) != $past(next_pc)));

  // R11
  ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && !sel_is_reset && sel_code != EC_COP_OFF) |=> cause_ce == '0);

  // R8
  refill_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && sel_is_refill && !status_exl) |=> fetch_addr == $past(ebase));

  // R10
  reset_req_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && sel_is_reset) |=> (fetch_addr == RESET_VEC) && status_bev);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.SRS_W(SRS_W), .COP_W(COP_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_vec       (req_vec),
  .pc            (pc),
  .next_pc       (next_pc),
  .taken         (taken),
  .fetch_addr    (fetch_addr),
  .status_exl    (status_exl),
  .status_bev    (status_bev),
  .ebase         (ebase),
  .srs_ess       (srs_ess),
  .srs_css       (srs_css),
  .srs_pss       (srs_pss),
  .cause_bd      (cause_bd),
  .cause_ce      (cause_ce),
  .exc_fire      (exc_fire),
  .sel_code      (sel_code),
  .sel_is_reset  (sel_is_reset),
  .sel_is_refill (sel_is_refill)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] req_vec = '0;
  logic [31:0] pc = '0, next_pc = '0, fault_addr = '0, sw_wdata = '0;
  logic [1:0]  cop_id = '0;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_sel = '0;
  logic        taken, status_exl, status_bev, cause_bd, cause_iv;
  logic [31:0] fetch_addr, ebase, epc, badvaddr;
  logic [3:0]  srs_ess, srs_css, srs_pss;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce;
  logic [18:0] entryhi_vpn2, context_vpn2;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .pc(pc), .next_pc(next_pc),
    .fault_addr(fault_addr), .cop_id(cop_id), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .taken(taken), .fetch_addr(fetch_addr),
    .status_exl(status_exl), .status_bev(status_bev), .ebase(ebase),
    .srs_ess(srs_ess), .srs_css(srs_css), .srs_pss(srs_pss),
    .cause_code(cause_code), .cause_bd(cause_bd), .cause_ce(cause_ce),
    .cause_iv(cause_iv), .epc(epc), .badvaddr(badvaddr),
    .entryhi_vpn2(entryhi_vpn2), .context_vpn2(context_vpn2)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // entry: drive request for one cycle; outputs are settled on return
  task automatic fire(input logic [17:0] r, input logic [31:0] p, input logic [31:0] np,
                      input logic [31:0] fa);
    @(negedge clk);
    req_vec = r; pc = p; next_pc = np; fault_addr = fa;
    @(negedge clk);
    req_vec = '0;
  endtask

  task automatic swr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = s; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  function automatic logic [17:0] bit_of(input int i);
    return 18'(1) << i;
  endfunction

  task automatic t_reset_state();
    chk("R10 reset fetch", fetch_addr, 32'hBFC0_0000);
    chk("R10 reset exl", status_exl, 1);
    chk("R10 reset bev", status_bev, 1);
    chk("R1 reset taken", taken, 0);
  endtask

  task automatic t_sw_setup();
    swr(3'd0, 32'h0);
    swr(3'd3, 32'h0000_0035);
    chk("R13 sw exl", status_exl, 0);
    chk("R13 sw bev", status_bev, 0);
    chk("R13 sw ess", srs_ess, 5);
    chk("R13 sw css", srs_css, 3);
    chk("R13 sw pss", srs_pss, 0);
  endtask

  task automatic t_syscall_plain();
    fire(bit_of(7), 32'h1000, 32'h1004, 32'h0);
    chk("R1 taken pulse", taken, 1);
    chk("R7 general vector", fetch_addr, 32'h8000_0180);
    chk("R3 syscall code", cause_code, 5'h08);
    chk("R4 epc plain", epc, 32'h1000);
    chk("R4 bd clear", cause_bd, 0);
    chk("R5 exl set", status_exl, 1);
    chk("R6 rotate pss", srs_pss, 3);
    chk("R6 rotate css", srs_css, 5);
    @(negedge clk);
    chk("R1 taken drops", taken, 0);
    chk("R1 fetch holds", fetch_addr, 32'h8000_0180);
  endtask

  task automatic t_break_slot();
    swr(3'd3, 32'h0000_0127);
    swr(3'd0, 32'h1);
    fire(bit_of(8), 32'h2000, 32'h3000, 32'h0);
    chk("R3 break code", cause_code, 5'h09);
    chk("R4 epc rewound", epc, 32'h1FFC);
    chk("R4 bd set", cause_bd, 1);
    chk("R5 exl stays", status_exl, 1);
    chk("R6 hold pss under exl", srs_pss, 1);
    chk("R6 hold css under exl", srs_css, 2);
  endtask

  task automatic t_refill();
    fire(bit_of(13), 32'h100, 32'h104, 32'h0040_6000);
    chk("R8 refill exl=1 vector", fetch_addr, 32'h8000_0180);
    chk("R3 load refill code", cause_code, 5'h02);
    chk("R12 refill badvaddr", badvaddr, 32'h0040_6000);
    chk("R12 refill entryhi", entryhi_vpn2, 19'(32'h0040_6000 >> 13));
    swr(3'd0, 32'h0);
    fire(bit_of(14), 32'h200, 32'h204, 32'h1234_E000);
    chk("R8 refill exl=0 vector", fetch_addr, 32'h8000_0000);
    chk("R3 store refill code", cause_code, 5'h03);
    chk("R12 refill context", context_vpn2, 19'(32'h1234_E000 >> 13));
    swr(3'd0, 32'h2);
    fire(bit_of(3), 32'h300, 32'h304, 32'h0000_4000);
    chk("R8 refill ignores bev", fetch_addr, 32'h8000_0000);
  endtask

  task automatic t_bev();
    swr(3'd3, 32'h0000_0127);
    swr(3'd0, 32'h2);
    fire(bit_of(9), 32'h400, 32'h404, 32'h0);
    chk("R7 boot vector", fetch_addr, 32'hBFC0_0200);
    chk("R3 overflow code", cause_code, 5'h0C);
    chk("R6 hold css under bev", srs_css, 2);
    chk("R6 hold pss under bev", srs_pss, 1);
  endtask

  task automatic t_irq();
    swr(3'd0, 32'h0);
    swr(3'd1, 32'h1);
    fire(bit_of(1), 32'h500, 32'h504, 32'h0);
    chk("R9 vectored irq", fetch_addr, 32'h8000_0200);
    chk("R3 irq code", cause_code, 5'h00);
    chk("R6 irq rotate css", srs_css, 7);
    chk("R6 irq rotate pss", srs_pss, 2);
    swr(3'd0, 32'h0);
    swr(3'd1, 32'h0);
    fire(bit_of(1), 32'h500, 32'h504, 32'h0);
    chk("R9 plain irq", fetch_addr, 32'h8000_0180);
  endtask

  task automatic t_cop();
    cop_id = 2'd2;
    fire(bit_of(6), 32'h600, 32'h604, 32'h0);
    chk("R11 ce loaded", cause_ce, 2);
    chk("R3 cop code", cause_code, 5'h0B);
    fire(bit_of(10), 32'h700, 32'h704, 32'h0);
    chk("R11 ce cleared", cause_ce, 0);
    chk("R3 trap code", cause_code, 5'h0D);
    fire(bit_of(5), 32'h700, 32'h704, 32'h0);
    chk("R3 illegal code", cause_code, 5'h0A);
    cop_id = 2'd0;
  endtask

  task automatic t_addr();
    fire(bit_of(11), 32'h800, 32'h804, 32'hDEAD_BEE1);
    chk("R3 load addr code", cause_code, 5'h04);
    chk("R12 addr badvaddr", badvaddr, 32'hDEAD_BEE1);
    fire(bit_of(7), 32'h900, 32'h904, 32'h1111_1111);
    chk("R12 syscall leaves badvaddr", badvaddr, 32'hDEAD_BEE1);
    fire(bit_of(12), 32'hA00, 32'hA04, 32'hCAFE_0002);
    chk("R3 store addr code", cause_code, 5'h05);
    fire(bit_of(17), 32'hA00, 32'hA04, 32'h00AB_C000);
    chk("R3 tlb mod code", cause_code, 5'h01);
    chk("R12 mod entryhi", entryhi_vpn2, 19'(32'h00AB_C000 >> 13));
    fire(bit_of(4), 32'hB00, 32'hB04, 32'h0002_0000);
    chk("R3 fetch invalid code", cause_code, 5'h02);
  endtask

  task automatic t_prio();
    fire(bit_of(1) | bit_of(7) | bit_of(12), 32'hC00, 32'hC04, 32'h5);
    chk("R2 irq beats decode and data", cause_code, 5'h00);
    fire(bit_of(7) | bit_of(11), 32'hC00, 32'hC04, 32'h5);
    chk("R2 decode beats data", cause_code, 5'h08);
    fire(bit_of(2) | bit_of(5), 32'hC00, 32'hC04, 32'h44);
    chk("R2 fetch beats decode", cause_code, 5'h04);
    fire(bit_of(16) | bit_of(17), 32'hC00, 32'hC04, 32'h6000);
    chk("R2 lower index wins", cause_code, 5'h03);
  endtask

  task automatic t_ebase_and_collide();
    swr(3'd2, 32'h9000_0ABC);
    chk("R13 ebase low bits masked", ebase, 32'h9000_0000);
    swr(3'd0, 32'h0);
    fire(bit_of(7), 32'hD00, 32'hD04, 32'h0);
    chk("R7 new ebase vector", fetch_addr, 32'h9000_0180);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = 3'd4; sw_wdata = 32'h7777_0000; req_vec = bit_of(8);
    pc = 32'hE00; next_pc = 32'hE04;
    @(negedge clk);
    sw_we = 1'b0; req_vec = '0;
    chk("R13 entry beats sw write", epc, 32'hE00);
  endtask

  task automatic t_reset_req();
    fire(bit_of(0) | bit_of(7), 32'hF00, 32'hF08, 32'h0);
    chk("R10 reset req vector", fetch_addr, 32'hBFC0_0000);
    chk("R10 reset req bev", status_bev, 1);
    chk("R10 reset req exl", status_exl, 1);
    chk("R10 reset req keeps code", cause_code, 5'h09);
    chk("R10 reset req keeps epc", epc, 32'hE00);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_sw_setup();
    t_syscall_plain();
    t_break_slot();
    t_refill();
    t_bev();
    t_irq();
    t_cop();
    t_addr();
    t_prio();
    t_ebase_and_collide();
    t_reset_req();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule